// File: doc/BRIEF.md
# Shift and Rotate Execute Unit

This unit performs the shift and rotate instructions of a 64-bit core in the execute stage. It takes the instruction word, the source operand and, for variable forms, the value of the shift-amount register. One cycle later it returns the result, a valid flag and a reserved-instruction flag. It supports left shift, arithmetic right shift, logical right shift and rotate right. Each operation comes in a 32-bit word form and a 64-bit doubleword form. The amount comes either from an immediate field or from a register.

Logical right shift and rotate right share one function code. A 5-bit selector field tells them apart. For immediate forms the selector is bits 25:21. For variable forms it is bits 10:6, which in those forms are not an amount. A selector value above 1 is a reserved encoding. In that case the unit raises the exception flag and returns no result.

Word forms act only on the low 32 bits of the source, and their 32-bit result is sign-extended to 64 bits. The doubleword "+32" immediate forms add 32 to the 5-bit immediate, so they reach amounts 32 to 63.

Top module: `shrot_unit`

## Requirements
- R1: While rst_ni is low, valid_o, ri_exc_o and result_o are all zero.
- R2: Outputs are registered with one cycle of latency. A cycle with valid_i low makes valid_o and ri_exc_o low on the next cycle.
- R3: An instruction is a shift only when bits 31:26 are zero and bits 5:0 hold one of these codes: 0x00, 0x02, 0x03, 0x04, 0x06, 0x07, 0x14, 0x16, 0x17, 0x38, 0x3A, 0x3B, 0x3C, 0x3E or 0x3F. Any other instruction gives valid_o=0, ri_exc_o=0 and result_o=0.
- R4: Word forms act on src_i[31:0]. The immediate word forms take their amount from bits 10:6: 0x00 is left shift, 0x03 is arithmetic right, and 0x02 is right shift or rotate. The 32-bit result is sign-extended into result_o[63:32].
- R5: Variable word forms take their amount from amt_i[4:0]: 0x04 is left shift, 0x07 is arithmetic right, and 0x06 is right shift or rotate. Variable doubleword forms take their amount from amt_i[5:0]: 0x14 is left shift, 0x17 is arithmetic right, and 0x16 is right shift or rotate. All higher bits of amt_i are ignored.
- R6: Doubleword immediate forms 0x38, 0x3B and 0x3A use bits 10:6 as the amount. The forms 0x3C, 0x3F and 0x3E use 32 plus bits 10:6. In both sets the operations are, in that order, left shift, arithmetic right shift, and right shift or rotate.
- R7: Arithmetic right shift fills vacated bits with bit 31 of the source for word forms and with bit 63 for doubleword forms.
- R8: For the immediate right-shift codes 0x02, 0x3A and 0x3E, bits 25:21 select the operation: 0 is logical right shift, 1 is rotate right, and any value from 2 to 31 raises the reserved-instruction exception.
- R9: For the variable right-shift codes 0x06 and 0x16, bits 10:6 are the selector, with the same rule as R8.
- R10: Rotate right by n over width W returns (x >> n) | (x << (W-n)). A rotate by zero returns the operand unchanged, never zero.
- R11: When the exception is raised, ri_exc_o is 1, valid_o is 0 and result_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Instruction present this cycle |
| instr_i | input | 32 | Instruction word |
| src_i | input | DATA_W | Operand to shift |
| amt_i | input | DATA_W | Shift-amount register value (variable forms) |
| valid_o | output | 1 | Result valid |
| result_o | output | DATA_W | Shifted or rotated result |
| ri_exc_o | output | 1 | Reserved-instruction exception |

## Verification
A wrong decode (the wrong operation, width or amount source) shows up one cycle later as a wrong result_o for that instruction. A wrong selector decode shows up one cycle later as a missing or spurious ri_exc_o. The bench sweeps every function code over every amount with operands whose upper halves hold values that must not leak into the result. That way a corrupted word lane, a missing sign extension or a rotate-by-zero error appears on the first affected operation. All 32 selector values are tried on each right-shift form.

// File: rtl/shrot_pkg.sv
package shrot_pkg;
  typedef enum logic [1:0] {
    SH_LEFT  = 2'd0,
    SH_RLOG  = 2'd1,
    SH_RARI  = 2'd2,
    SH_ROTR  = 2'd3
  } shop_e;
endpackage

// File: rtl/shrot_decode.sv
module shrot_decode
  import shrot_pkg::*;
#(
  parameter int DATA_W = 64,
  localparam int AMT_W = $clog2(DATA_W)
) (
  input  logic [5:0]       opc_i,
  input  logic [5:0]       fn_i,
  input  logic [4:0]       sel_hi_i,
  input  logic [4:0]       sa_i,
  input  logic [AMT_W-1:0] amt_reg_i,
  output logic             hit_o,
  output logic             exc_o,
  output logic             dword_o,
  output shop_e            op_o,
  output logic [AMT_W-1:0] amt_o
);
  localparam logic [AMT_W-1:0] HALF = AMT_W'(DATA_W / 2);

  logic [AMT_W-1:0] sa_w;
  logic [AMT_W-1:0] reg_w;
  assign sa_w  = AMT_W'(sa_i);
  assign reg_w = AMT_W'(amt_reg_i[AMT_W-2:0]);

  // selector: 0 logical, 1 rotate, other reserved
  function automatic void pick_right(input logic [4:0] sel, output shop_e op, output logic bad);
    op  = (sel == 5'd1) ? SH_ROTR : SH_RLOG;
    bad = (sel > 5'd1);
  endfunction

  always_comb begin
    hit_o   = 1'b0;
    exc_o   = 1'b0;
    dword_o = 1'b0;
    op_o    = SH_LEFT;
    amt_o   = '0;
    if (opc_i == 6'h00) begin
      unique case (fn_i)
        6'h00: begin hit_o = 1'b1; op_o = SH_LEFT; amt_o = sa_w; end
        6'h02: begin hit_o = 1'b1; pick_right(sel_hi_i, op_o, exc_o); amt_o = sa_w; end
        6'h03: begin hit_o = 1'b1; op_o = SH_RARI; amt_o = sa_w; end
        6'h04: begin hit_o = 1'b1; op_o = SH_LEFT; amt_o = reg_w; end
        6'h06: begin hit_o = 1'b1; pick_right(sa_i, op_o, exc_o); amt_o = reg_w; end
        6'h07: begin hit_o = 1'b1; op_o = SH_RARI; amt_o = reg_w; end
        6'h14: begin hit_o = 1'b1; dword_o = 1'b1; op_o = SH_LEFT; amt_o = amt_reg_i; end
        6'h16: begin hit_o = 1'b1; dword_o = 1'b1; pick_right(sa_i, op_o, exc_o); amt_o = amt_reg_i; end
        6'h17: begin hit_o = 1'b1; dword_o = 1'b1; op_o = SH_RARI; amt_o = amt_reg_i; end
        6'h38: begin hit_o = 1'b1; dword_o = 1'b1; op_o = SH_LEFT; amt_o = sa_w; end
        6'h3A: begin hit_o = 1'b1; dword_o = 1'b1; pick_right(sel_hi_i, op_o, exc_o); amt_o = sa_w; end
        6'h3B: begin hit_o = 1'b1; dword_o = 1'b1; op_o = SH_RARI; amt_o = sa_w; end
        6'h3C: begin hit_o = 1'b1; dword_o = 1'b1; op_o = SH_LEFT; amt_o = HALF + sa_w; end
        6'h3E: begin hit_o = 1'b1; dword_o = 1'b1; pick_right(sel_hi_i, op_o, exc_o); amt_o = HALF + sa_w; end
        6'h3F: begin hit_o = 1'b1; dword_o = 1'b1; op_o = SH_RARI; amt_o = HALF + sa_w; end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/shrot_datapath.sv
module shrot_datapath
  import shrot_pkg::*;
#(
  parameter int DATA_W = 64,
  localparam int AMT_W = $clog2(DATA_W),
  localparam int HW    = DATA_W / 2
) (
  input  logic [DATA_W-1:0] src_i,
  input  logic              dword_i,
  input  shop_e             op_i,
  input  logic [AMT_W-1:0]  amt_i,
  output logic [DATA_W-1:0] res_o
);
  logic [HW-1:0]       w_src, w_res;
  logic [AMT_W-2:0]    w_amt;
  logic [2*HW-1:0]     w_dbl;
  logic [2*DATA_W-1:0] d_dbl;
  logic [DATA_W-1:0]   d_res;

  assign w_src = src_i[HW-1:0];
  assign w_amt = amt_i[AMT_W-2:0];
  // rotate through a doubled operand: amount 0 returns the operand
  assign w_dbl = {w_src, w_src} >> w_amt;
  assign d_dbl = {src_i, src_i} >> amt_i;

  always_comb begin
    unique case (op_i)
      SH_LEFT: w_res = w_src << w_amt;
      SH_RLOG: w_res = w_src >> w_amt;
      SH_RARI: w_res = $unsigned($signed(w_src) >>> w_amt);
      default: w_res = w_dbl[HW-1:0];
    endcase
  end

  always_comb begin
    unique case (op_i)
      SH_LEFT: d_res = src_i << amt_i;
      SH_RLOG: d_res = src_i >> amt_i;
      SH_RARI: d_res = $unsigned($signed(src_i) >>> amt_i);
      default: d_res = d_dbl[DATA_W-1:0];
    endcase
  end

  assign res_o = dword_i ? d_res : {{HW{w_res[HW-1]}}, w_res};
endmodule

// File: rtl/shrot_unit.sv
module shrot_unit
  import shrot_pkg::*;
#(
  parameter int DATA_W = 64,
  localparam int AMT_W = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [31:0]       instr_i,
  input  logic [DATA_W-1:0] src_i,
  input  logic [DATA_W-1:0] amt_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] result_o,
  output logic              ri_exc_o
);
  logic             dec_hit, dec_exc, dec_dword;
  shop_e            dec_op;
  logic [AMT_W-1:0] dec_amt;
  logic [DATA_W-1:0] dp_res;
  logic             unused_fields;

  assign unused_fields = ^{instr_i[20:11], amt_i[DATA_W-1:AMT_W]};

  shrot_decode #(.DATA_W(DATA_W)) u_dec (
    .opc_i     (instr_i[31:26]),
    .fn_i      (instr_i[5:0]),
    .sel_hi_i  (instr_i[25:21]),
    .sa_i      (instr_i[10:6]),
    .amt_reg_i (amt_i[AMT_W-1:0]),
    .hit_o     (dec_hit),
    .exc_o     (dec_exc),
    .dword_o   (dec_dword),
    .op_o      (dec_op),
    .amt_o     (dec_amt)
  );

  shrot_datapath #(.DATA_W(DATA_W)) u_dp (
    .src_i   (src_i),
    .dword_i (dec_dword),
    .op_i    (dec_op),
    .amt_i   (dec_amt),
    .res_o   (dp_res)
  );

  logic fire;
  assign fire = valid_i & dec_hit & ~dec_exc;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      ri_exc_o <= 1'b0;
      result_o <= '0;
    end else begin
      valid_o  <= fire;
      ri_exc_o <= valid_i & dec_hit & dec_exc;
      result_o <= fire ? dp_res : '0;
    end
  end

  AST_EXC_NO_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ri_exc_o |-> (!valid_o && result_o == '0)); // R11
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!valid_o && !ri_exc_o)); // R2
  AST_NOT_SHIFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && instr_i[31:26] != 6'h00) |=> (!valid_o && !ri_exc_o)); // R3
  AST_IMM_SEL_RSVD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && instr_i[31:26] == 6'h00 && instr_i[25:21] > 5'd1 &&
     (instr_i[5:0] == 6'h02 || instr_i[5:0] == 6'h3A || instr_i[5:0] == 6'h3E))
    |=> ri_exc_o); // R8
  AST_VAR_SEL_RSVD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && instr_i[31:26] == 6'h00 && instr_i[10:6] > 5'd1 &&
     (instr_i[5:0] == 6'h06 || instr_i[5:0] == 6'h16))
    |=> ri_exc_o); // R9
  AST_WORD_SEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && !dec_dword) |=> (result_o[DATA_W-1:DATA_W/2] == {(DATA_W/2){result_o[DATA_W/2-1]}})); // R4
  AST_ROT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && dec_dword && dec_op == SH_ROTR && dec_amt == '0) |=> (result_o == $past(src_i))); // R10
endmodule

// File: tb/shrot_unit_tb.sv
module shrot_unit_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [31:0] instr_i = '0;
  logic [63:0] src_i = '0;
  logic [63:0] amt_i = '0;
  logic        valid_o, ri_exc_o;
  logic [63:0] result_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  shrot_unit #(.DATA_W(64)) dut_i (
    .clk_i, .rst_ni, .valid_i, .instr_i, .src_i, .amt_i,
    .valid_o, .result_o, .ri_exc_o
  );

  function automatic logic [31:0] mk(input logic [5:0] opc, input logic [4:0] hi,
                                     input logic [4:0] sa, input logic [5:0] fn);
    return {opc, hi, 5'd3, 5'd7, sa, fn};
  endfunction

  // reference: {valid, exc, result}
  function automatic logic [65:0] model(input logic [31:0] ins, input logic [63:0] s,
                                        input logic [63:0] a);
    int w, n, kind;
    bit ok, bad;
    logic [4:0] sa, hi;
    logic [63:0] x, r;
    sa = ins[10:6]; hi = ins[25:21];
    ok = 1; bad = 0; w = 32; n = 0; kind = 0;
    if (ins[31:26] != 0) ok = 0;
    else case (ins[5:0])
      6'h00: begin kind = 0; n = sa; end
      6'h02: begin kind = (hi == 1) ? 3 : 1; bad = hi > 1; n = sa; end
      6'h03: begin kind = 2; n = sa; end
      6'h04: begin kind = 0; n = a % 32; end
      6'h06: begin kind = (sa == 1) ? 3 : 1; bad = sa > 1; n = a % 32; end
      6'h07: begin kind = 2; n = a % 32; end
      6'h14: begin w = 64; kind = 0; n = a % 64; end
      6'h16: begin w = 64; kind = (sa == 1) ? 3 : 1; bad = sa > 1; n = a % 64; end
      6'h17: begin w = 64; kind = 2; n = a % 64; end
      6'h38: begin w = 64; kind = 0; n = sa; end
      6'h3A: begin w = 64; kind = (hi == 1) ? 3 : 1; bad = hi > 1; n = sa; end
      6'h3B: begin w = 64; kind = 2; n = sa; end
      6'h3C: begin w = 64; kind = 0; n = 32 + sa; end
      6'h3E: begin w = 64; kind = (hi == 1) ? 3 : 1; bad = hi > 1; n = 32 + sa; end
      6'h3F: begin w = 64; kind = 2; n = 32 + sa; end
      default: ok = 0;
    endcase
    if (!ok) return 66'd0;
    if (bad) return {1'b0, 1'b1, 64'd0};
    x = (w == 32) ? {32'd0, s[31:0]} : s;
    r = '0;
    for (int i = 0; i < w; i++) begin
      case (kind)
        0: r[i] = (i >= n) ? x[i-n] : 1'b0;
        1: r[i] = (i + n < w) ? x[i+n] : 1'b0;
        2: r[i] = (i + n < w) ? x[i+n] : x[w-1];
        default: r[i] = x[(i+n)%w];
      endcase
    end
    if (w == 32) for (int i = 32; i < 64; i++) r[i] = r[31];
    return {1'b1, 1'b0, r};
  endfunction

  task automatic check(input string tag, input logic [65:0] exp);
    n_cmp++;
    if ({valid_o, ri_exc_o, result_o} !== exp) begin
      n_bad++;
      $display("FAIL %s instr=%h actual v=%b x=%b r=%h expected v=%b x=%b r=%h", tag, instr_i,
               valid_o, ri_exc_o, result_o, exp[65], exp[64], exp[63:0]);
    end
  endtask

  // called at a negedge; drives, then checks at the following negedge
  task automatic apply(input logic [31:0] ins, input logic [63:0] s, input logic [63:0] a,
                       input string tag);
    logic [65:0] e;
    e = model(ins, s, a);
    valid_i = 1'b1; instr_i = ins; src_i = s; amt_i = a;
    @(negedge clk_i);
    check(tag, e);
  endtask

  function automatic string tag_of(input logic [5:0] fn, input bit rot, input bit exc);
    if (exc) return (fn == 6'h06 || fn == 6'h16) ? "R9/R11" : "R8/R11";
    if (rot) return "R10";
    case (fn)
      6'h03, 6'h07, 6'h17, 6'h3B, 6'h3F: return "R7";
      6'h00, 6'h02: return "R4";
      6'h04, 6'h06, 6'h14, 6'h16: return "R5";
      default: return "R6";
    endcase
  endfunction

  localparam logic [5:0] FNS [15] = '{6'h00, 6'h02, 6'h03, 6'h04, 6'h06, 6'h07, 6'h14,
                                      6'h16, 6'h17, 6'h38, 6'h3A, 6'h3B, 6'h3C, 6'h3E, 6'h3F};
  localparam logic [63:0] SRCS [4] = '{64'h0123_4567_89AB_CDEF, 64'hF0E1_D2C3_8000_0001,
                                       64'h8000_0000_7FFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF};

  initial begin
    repeat (3) @(negedge clk_i);
    n_cmp++;
    if (valid_o !== 1'b0 || ri_exc_o !== 1'b0 || result_o !== 64'd0) begin
      n_bad++;
      $display("FAIL R1 reset actual v=%b x=%b r=%h expected 0 0 0", valid_o, ri_exc_o, result_o);
    end
    rst_ni = 1'b1;
    @(negedge clk_i);

    // main sweep: every code, operand and amount; selector 0 and 1
    foreach (FNS[f]) begin
      for (int sv = 0; sv < 4; sv++) begin
        for (int rot = 0; rot < 2; rot++) begin
          for (int n = 0; n < 64; n++) begin
            logic [5:0] fn;
            bit is_var, is_rgt;
            logic [4:0] hi, sa;
            fn = FNS[f];
            is_var = (fn[5:3] != 3'b111);
            is_var = is_var && (fn[2] == 1'b1);
            is_rgt = (fn[1:0] == 2'b10);
            if (rot == 1 && !is_rgt) continue;
            if (!is_var && n >= 32) continue;
            hi = (!is_var && rot == 1) ? 5'd1 : 5'd0;
            sa = is_var ? ((rot == 1) ? 5'd1 : 5'd0) : n[4:0];
            apply(mk(6'h00, hi, sa, fn), SRCS[sv],
                  {58'h2A5_5A5A_F00D_C0DE, n[5:0]}, tag_of(fn, rot == 1, 1'b0));
          end
        end
      end
    end

    // every selector value on each right-shift form
    for (int sel = 0; sel < 32; sel++) begin
      int amts [5] = '{0, 1, 31, 32, 63};
      foreach (amts[k]) begin
        logic [4:0] s5;
        s5 = sel[4:0];
        apply(mk(6'h00, s5, amts[k][4:0], 6'h02), SRCS[k % 4], 64'd0, tag_of(6'h02, sel == 1, sel > 1));
        apply(mk(6'h00, s5, amts[k][4:0], 6'h3A), SRCS[k % 4], 64'd0, tag_of(6'h3A, sel == 1, sel > 1));
        apply(mk(6'h00, s5, amts[k][4:0], 6'h3E), SRCS[k % 4], 64'd0, tag_of(6'h3E, sel == 1, sel > 1));
        apply(mk(6'h00, 5'd0, s5, 6'h06), SRCS[k % 4], 64'(amts[k]), tag_of(6'h06, sel == 1, sel > 1));
        apply(mk(6'h00, 5'd0, s5, 6'h16), SRCS[k % 4], 64'(amts[k]), tag_of(6'h16, sel == 1, sel > 1));
      end
    end

    // non-shift encodings
    apply(mk(6'h08, 5'd0, 5'd4, 6'h00), SRCS[0], 64'd3, "R3");
    apply(mk(6'h00, 5'd0, 5'd4, 6'h20), SRCS[1], 64'd3, "R3");
    apply(mk(6'h00, 5'd1, 5'd4, 6'h01), SRCS[2], 64'd3, "R3");
    apply(mk(6'h23, 5'd1, 5'd1, 6'h3E), SRCS[3], 64'd3, "R3");

    // idle after an exception and after a valid result
    apply(mk(6'h00, 5'd5, 5'd2, 6'h02), SRCS[0], 64'd0, "R11");
    valid_i = 1'b0;
    @(negedge clk_i);
    check("R2", 66'd0);
    apply(mk(6'h00, 5'd0, 5'd2, 6'h38), SRCS[0], 64'd0, "R6");
    valid_i = 1'b0;
    instr_i = mk(6'h00, 5'd0, 5'd2, 6'h38);
    @(negedge clk_i);
    check("R2", 66'd0);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL R2 watchdog actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule